// File: doc/BRIEF.md
# Prioritized nested interrupt controller

This block decides which peripheral interrupt a small 8-bit CPU services next. Every source has a pending latch, an enable bit, a 2-bit software level and a flag that marks it as able to end a halt. A peripheral event pulse sets the latch. The latch clears when software runs that source's clear sequence, or when the block grants the source. The request that wins has the highest software level. When two requests share a level, the lower source index wins. Index 0 is the top-level source. The highest index has the lowest fixed rank, and the main program sits below all of them.

The block holds the CPU's current level. Level 3 is the highest level, and the main program runs at level 3 while interrupts are disabled. A grant saves the current level on a 4-entry stack and raises the CPU level to the level of the granted source. A return pulse pops the saved level back. There are two modes. In concurrent mode, a new grant waits until no handler is active. In nested mode, a request whose level is strictly above the CPU level preempts the running handler.

While the CPU sleeps, the block raises a wake line. In wait, any enabled request raises it. In halt, only a halt-capable request raises it. After a halt, the first grant goes to a halt-capable source. Normal arbitration then resumes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source requests only while its pending latch is set and its enable bit is 1. A disabled source keeps its latch, and it is granted once it is enabled.
- R2: Among eligible requests, the one with the highest software level (lvl_i bits [2i+1:2i] of source i, 2'b11 highest) is granted first.
- R3: Among requests at equal level, the lowest source index is granted first. Index 0 is the top-level source.
- R4: A grant needs a request level strictly above cpu_lvl_o. After reset, cpu_lvl_o is 3, so every source is masked.
- R5: When nest_i is 0 (concurrent mode), no grant happens while any handler level is saved on the stack.
- R6: When nest_i is 1 (nested mode), a request whose level is strictly above cpu_lvl_o preempts the running handler. A request at equal level waits.
- R7: At a grant, the previous cpu_lvl_o is pushed and cpu_lvl_o takes the granted source's level. Each rti_i pulse restores the last saved level. cpu_lvl_o changes only on a grant, a return or a lvl_wr_i write.
- R8: When the level stack holds 4 entries, no grant is issued. A grant can happen again after a return.
- R9: wake_o is 1 when wait_i is 1 and any request exists, or when halt_i is 1 and a halt-capable request (halt_cap_i bit set) exists.
- R10: The first grant after a halt goes to a halt-capable source, even when a higher-ranked non-capable request is pending. The non-capable request is granted at the next opportunity.
- R11: clr_i clears a source's pending latch, so the pending request is lost. A clear in the same cycle as an event pulse wins.
- R12: ack_o is a one-cycle pulse, and vec_o holds the granted index while ack_o is 1. The granted source's latch is cleared, so that source is not granted again without a new event.
- R13: No grant is issued while halt_i or wait_i is 1. An rti_i pulse with an empty stack leaves cpu_lvl_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | N_SRC | Event pulse per source, sets its pending latch |
| clr_i | input | N_SRC | Clear sequence per source, drops its pending latch |
| en_i | input | N_SRC | Enable bit per source |
| lvl_i | input | 2*N_SRC | Software level per source, 2 bits each |
| halt_cap_i | input | N_SRC | Source may end a halt |
| nest_i | input | 1 | 1 selects nested mode, 0 selects concurrent mode |
| halt_i | input | 1 | CPU is in halt |
| wait_i | input | 1 | CPU is in wait |
| lvl_wr_i | input | 1 | Write the CPU level |
| lvl_wdata_i | input | 2 | Level value to write |
| rti_i | input | 1 | Return-from-interrupt pulse |
| wake_o | output | 1 | Wake request to the sleeping CPU |
| ack_o | output | 1 | Grant pulse |
| vec_o | output | clog2(N_SRC) | Granted source index |
| cpu_lvl_o | output | 2 | Current CPU level |

## Verification
The arbiter sees several request mixes. Two sources at different levels with reversed fixed rank show that the software level decides before the fixed order does. Two sources at equal level show that the fixed order breaks the tie. An equal-level request and a higher-level request arrive during a running handler. In concurrent mode the bench checks that neither preempts. In nested mode it checks that only the strictly higher one does. After a halt, a high-level non-capable request and a low-level capable request are both pending. This pair separates the halt-wake rule from plain arbitration.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'b11;
endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] take_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    pend_o[g] <= 1'b0;
      else if (clr_i[g] || take_i[g]) pend_o[g] <= 1'b0;  // clear beats a new event
      else if (flag_i[g])             pend_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand_i,
  input  lvl_t             lvl_i [N_SRC],
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    // walk from lowest rank upward; >= lets a lower index take a tie
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!any_o || lvl_i[i] >= lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
  import prio_irq_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t din_i,
  output lvl_t top_o,
  output logic empty_o,
  output logic full_o
);
  localparam int unsigned CNT_W = $clog2(STK_DEPTH + 1);
  localparam int unsigned ADR_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;

  lvl_t             mem_q [STK_DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;

  assign top_idx = cnt_q - CNT_W'(1);
  assign top_o   = mem_q[top_idx[ADR_W-1:0]];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(STK_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < STK_DEPTH; i++) mem_q[i] <= LVL_TOP;
    end else if (pop_i && !empty_o) begin
      cnt_q <= top_idx;
    end else if (push_i && !full_o) begin
      mem_q[cnt_q[ADR_W-1:0]] <= din_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC     = 6,
  parameter int unsigned STK_DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SRC-1:0]         flag_i,
  input  logic [N_SRC-1:0]         clr_i,
  input  logic [N_SRC-1:0]         en_i,
  input  logic [2*N_SRC-1:0]       lvl_i,
  input  logic [N_SRC-1:0]         halt_cap_i,
  input  logic                     nest_i,
  input  logic                     halt_i,
  input  logic                     wait_i,
  input  logic                     lvl_wr_i,
  input  logic [1:0]               lvl_wdata_i,
  input  logic                     rti_i,
  output logic                     wake_o,
  output logic                     ack_o,
  output logic [$clog2(N_SRC)-1:0] vec_o,
  output logic [1:0]               cpu_lvl_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] pend, req, cap_req, cand, take;
  lvl_t             src_lvl [N_SRC];
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  lvl_t             cpu_lvl_q, stk_top;
  logic             stk_empty, stk_full;
  logic             hwake_q, grant, pop, sleeping, mode_ok;
  logic             ack_q;
  logic [IDX_W-1:0] vec_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    assign src_lvl[g] = lvl_i[2*g +: 2];
  end

  prio_irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .flag_i(flag_i), .clr_i(clr_i),
    .take_i(take), .pend_o(pend)
  );

  assign req     = pend & en_i;
  assign cap_req = req & halt_cap_i;
  assign wake_o  = (halt_i && |cap_req) || (wait_i && |req);

  // after a halt only halt-capable sources compete, until one is granted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hwake_q <= 1'b0;
    else if (halt_i)               hwake_q <= 1'b1;
    else if (grant || !(|cap_req)) hwake_q <= 1'b0;
  end

  assign cand = hwake_q ? cap_req : req;

  prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .cand_i(cand), .lvl_i(src_lvl), .any_o(win_any), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign sleeping = halt_i || wait_i;
  assign mode_ok  = nest_i || stk_empty;
  assign pop      = rti_i && !stk_empty;
  assign grant    = win_any && (win_lvl > cpu_lvl_q) && mode_ok && !stk_full &&
                    !sleeping && !rti_i && !lvl_wr_i;
  assign take     = grant ? (N_SRC'(1) << win_idx) : '0;

  prio_irq_stack #(.STK_DEPTH(STK_DEPTH)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(grant), .pop_i(pop),
    .din_i(cpu_lvl_q), .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_lvl_q <= LVL_TOP;
      ack_q     <= 1'b0;
      vec_q     <= '0;
    end else begin
      ack_q <= grant;
      if (grant) vec_q <= win_idx;
      if (pop)           cpu_lvl_q <= stk_top;
      else if (lvl_wr_i) cpu_lvl_q <= lvl_wdata_i;
      else if (grant)    cpu_lvl_q <= win_lvl;
    end
  end

  assign ack_o     = ack_q;
  assign vec_o     = vec_q;
  assign cpu_lvl_o = cpu_lvl_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned STK_DEPTH = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_o,
  input logic       nest_i,
  input logic       halt_i,
  input logic       wait_i,
  input logic       rti_i,
  input logic       lvl_wr_i,
  input logic [1:0] cpu_lvl_o
);
  logic [7:0] saved_q;
  logic [7:0] depth_now;

  // saved levels as seen from ports: the grant edge pushes, ack_o shows it
  assign depth_now = saved_q + {7'd0, ack_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) saved_q <= '0;
    else         saved_q <= depth_now - {7'd0, (rti_i && depth_now != '0)};
  end

  p_grant_raises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cpu_lvl_o > $past(cpu_lvl_o));

  p_conc_no_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !$past(nest_i)) |-> ($past(depth_now) == 8'd0));

  p_lvl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && !$past(rti_i) && !$past(lvl_wr_i)) |-> $stable(cpu_lvl_o));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(depth_now) < 8'(STK_DEPTH)));

  p_no_grant_asleep_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!$past(halt_i) && !$past(wait_i)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.STK_DEPTH(STK_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .nest_i(nest_i),
  .halt_i(halt_i), .wait_i(wait_i), .rti_i(rti_i), .lvl_wr_i(lvl_wr_i),
  .cpu_lvl_o(cpu_lvl_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] flag = '0, clr = '0, en = '1, cap = '0;
  logic [2*N-1:0] lvl = '0;
  logic nest = 1'b0, halt = 1'b0, wt = 1'b0, lvl_wr = 1'b0, rti = 1'b0;
  logic [1:0] lvl_wd = '0;
  logic wake, ack;
  logic [2:0] vec;
  logic [1:0] cpu_lvl;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag), .clr_i(clr), .en_i(en),
    .lvl_i(lvl), .halt_cap_i(cap), .nest_i(nest), .halt_i(halt), .wait_i(wt),
    .lvl_wr_i(lvl_wr), .lvl_wdata_i(lvl_wd), .rti_i(rti), .wake_o(wake),
    .ack_o(ack), .vec_o(vec), .cpu_lvl_o(cpu_lvl)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; flag = '0; clr = '0; en = '1; cap = '0; lvl = '0;
    nest = 1'b0; halt = 1'b0; wt = 1'b0; lvl_wr = 1'b0; rti = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_lvl(int s, int v);
    lvl[2*s +: 2] = 2'(v);
  endtask

  task automatic wr_lvl(int v);
    lvl_wr = 1'b1; lvl_wd = 2'(v); tick(); lvl_wr = 1'b0;
  endtask

  task automatic pulse_flag(logic [N-1:0] m);
    flag = m; tick(); flag = '0;
  endtask

  task automatic pulse_clr(logic [N-1:0] m);
    clr = m; tick(); clr = '0;
  endtask

  task automatic pulse_rti();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask

  // returns granted index, or -1 when no grant within max cycles
  task automatic wait_ack(output int got, input int max = 6);
    got = -1;
    for (int k = 0; k < max; k++) begin
      if (ack) begin got = int'(vec); break; end
      tick();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4 reset cpu level", cpu_lvl, 3);
    chk("R12 reset ack", ack, 0);
    chk("R9 reset wake", wake, 0);
  endtask

  task automatic t_mask();
    int g;
    do_reset();
    set_lvl(2, 2);
    pulse_flag(6'b000100);
    wait_ack(g, 4); chk("R4 masked at level 3", g, -1);
    wr_lvl(2);
    wait_ack(g, 4); chk("R4 equal level masked", g, -1);
    wr_lvl(1);
    wait_ack(g); chk("R4 unmasked grant", g, 2);
    chk("R7 level raised", cpu_lvl, 2);
    tick(); chk("R12 ack one cycle", ack, 0);
  endtask

  task automatic t_enable();
    int g;
    do_reset();
    set_lvl(3, 1); en[3] = 1'b0;
    wr_lvl(0);
    pulse_flag(6'b001000);
    wait_ack(g, 4); chk("R1 disabled no grant", g, -1);
    en[3] = 1'b1;
    wait_ack(g); chk("R1 enabled later grants", g, 3);
  endtask

  task automatic t_level();
    int g;
    do_reset();
    set_lvl(0, 1); set_lvl(4, 2);
    pulse_flag(6'b010001);
    wr_lvl(0);
    wait_ack(g); chk("R2 higher level first", g, 4);
    chk("R7 level of winner", cpu_lvl, 2);
    pulse_rti();
    wait_ack(g); chk("R2 lower level next", g, 0);
  endtask

  task automatic t_tie();
    int g;
    do_reset();
    set_lvl(1, 2); set_lvl(3, 2);
    pulse_flag(6'b001010);
    wr_lvl(0);
    wait_ack(g); chk("R3 lower index wins tie", g, 1);
    pulse_rti();
    wait_ack(g); chk("R3 other source next", g, 3);
  endtask

  task automatic t_conc();
    int g;
    do_reset();
    set_lvl(3, 1); set_lvl(0, 3);
    wr_lvl(0);
    pulse_flag(6'b001000);
    wait_ack(g); chk("R5 first handler", g, 3);
    pulse_flag(6'b000001);
    wait_ack(g, 5); chk("R5 no preemption", g, -1);
    pulse_rti();
    wait_ack(g); chk("R5 after return", g, 0);
    pulse_rti();
    wait_ack(g, 5); chk("R12 no repeat grant", g, -1);
  endtask

  task automatic t_nest();
    int g;
    do_reset();
    nest = 1'b1;
    set_lvl(5, 1); set_lvl(4, 1); set_lvl(2, 2);
    wr_lvl(0);
    pulse_flag(6'b100000);
    wait_ack(g); chk("R6 first handler", g, 5);
    chk("R7 level 1", cpu_lvl, 1);
    pulse_flag(6'b010000);
    wait_ack(g, 5); chk("R6 equal level waits", g, -1);
    pulse_flag(6'b000100);
    wait_ack(g); chk("R6 higher preempts", g, 2);
    chk("R7 level 2", cpu_lvl, 2);
    pulse_rti();
    chk("R7 restored to 1", cpu_lvl, 1);
    wait_ack(g, 4); chk("R6 equal still waits", g, -1);
    pulse_rti();
    wait_ack(g); chk("R6 granted at main", g, 4);
  endtask

  task automatic t_stack();
    int g;
    do_reset();
    nest = 1'b1;
    set_lvl(5, 1);
    wr_lvl(0);
    for (int k = 0; k < 4; k++) begin
      pulse_flag(6'b100000);
      wait_ack(g); chk("R8 fill stack", g, 5);
      wr_lvl(0);
    end
    pulse_flag(6'b100000);
    wait_ack(g, 6); chk("R8 full stack blocks", g, -1);
    pulse_rti();
    wait_ack(g); chk("R8 grant after return", g, 5);
  endtask

  task automatic t_sleep();
    int g;
    do_reset();
    cap = 6'b010000;
    set_lvl(3, 2); set_lvl(4, 1);
    wr_lvl(0);
    halt = 1'b1;
    pulse_flag(6'b001000);
    chk("R9 non-capable no halt wake", wake, 0);
    wait_ack(g, 3); chk("R13 no grant in halt", g, -1);
    pulse_flag(6'b010000);
    chk("R9 capable wakes halt", wake, 1);
    halt = 1'b0; wt = 1'b1;
    tick();
    chk("R9 wait wakes on any", wake, 1);
    wait_ack(g, 3); chk("R13 no grant in wait", g, -1);
    wt = 1'b0;
    wait_ack(g); chk("R10 capable served first", g, 4);
    pulse_rti();
    wait_ack(g); chk("R10 non-capable next", g, 3);
  endtask

  task automatic t_clear();
    int g;
    do_reset();
    set_lvl(2, 1);
    pulse_flag(6'b000100);
    pulse_clr(6'b000100);
    wr_lvl(0);
    wait_ack(g, 4); chk("R11 cleared is lost", g, -1);
    wr_lvl(3);
    flag = 6'b000100; clr = 6'b000100; tick(); flag = '0; clr = '0;
    wr_lvl(0);
    wait_ack(g, 4); chk("R11 clear wins same cycle", g, -1);
    pulse_flag(6'b000100);
    wait_ack(g); chk("R11 latch still works", g, 2);
  endtask

  task automatic t_rti_empty();
    do_reset();
    wr_lvl(1);
    pulse_rti();
    tick();
    chk("R13 return on empty stack", cpu_lvl, 1);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_enable();
    t_level();
    t_tie();
    t_conc();
    t_nest();
    t_stack();
    t_sleep();
    t_clear();
    t_rti_empty();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule